// File: doc/BRIEF.md
# Multithreaded Outstanding Miss Tracker

This block keeps the book of cache-line requests that several hardware threads have sent toward the memory system and that have not yet come back. Every live request sits in one small, fully associative array of slots. Each slot holds a valid bit, the owning thread, the request kind, the line address, a prefetch flag and an issue timestamp. The request kind places each slot in one of two logical tables, reads or writes. So each thread in effect owns a read table and a write table, and both are keyed by line address.

On the request side a combinational admission check reports whether a new request for a line may go out now. The limit on outstanding requests is global, and a line may have only one outstanding request across all threads and both tables. An insert port with valid/ready handshake then records the request. The insert port reports in the same cycle whether the request became a new miss to forward downstream or whether it overwrote an entry that already existed. On the completion side, one port carries a line address and a table selector, and the thread is optional. The tracker frees the matching slot. One cycle later it returns the owning thread and the prefetch flag. A data return to the requester is raised only for demand requests. The block also publishes live occupancy, demand and prefetch counts, plus a sticky flag for completions that matched nothing.

Back-pressure rules: an insert takes effect only in a cycle where both `ins_valid` and `ins_ready` are high. `ins_ready` is low only when every slot is in use and the insert would not overwrite an existing entry. While the port is not ready, the request's inputs may be held or changed freely and have no effect. Completions and responses cannot be stalled: each `cmp_valid` cycle is acted on at once, and `rsp_valid` is a single-cycle pulse.

Top module: `omt_tracker`

## Requirements
- R1: The kind code selects the table. Codes 4'h8 store, 4'h9 transactional store, 4'hA transactional exclusive load and 4'hB atomic (bit 3 set) go to the write table. Codes 4'h0 load, 4'h1 instruction fetch, 4'h2 transactional load, 4'h3 transaction begin and 4'h4 transaction commit go to the read table. A completion searches only the table chosen by `cmp_write` (1 = write table).
- R2: The key is the line address `addr[AW-1:OFFW]`. The low OFFW offset bits (default 4) are ignored on the admission, insert and completion ports.
- R3: `chk_ok` is 0 whenever `occ` is at least MAXOUT (default 6).
- R4: `chk_ok` is 0 whenever any valid entry, of any thread and in either table, has the same line as `chk_addr`. Otherwise `chk_ok` is 1.
- R5: An accepted insert whose thread, table and line match a valid entry overwrites that entry. In the same cycle it raises `ins_dup`, keeps `ins_fwd` low and leaves `occ` unchanged. Any other accepted insert creates an entry, raises `ins_fwd` and adds one to `occ`.
- R6: `ins_ready` is 0 only when all DEPTH slots are valid and the insert is not a duplicate. An insert presented while `ins_ready` is 0 changes nothing.
- R7: When `cmp_thr_known` is 1, a completion frees the matching entry of thread `cmp_thread`. When it is 0, the completion frees the matching entry with the smallest timestamp, and the lowest slot wins a tie. The cycle after, `rsp_valid` pulses with `rsp_thread` set to the owner of the freed entry.
- R8: `rsp_pf` carries the freed entry's prefetch flag. `rsp_deliver` is high only with `rsp_valid` and a demand (non-prefetch) entry.
- R9: `pf_cnt` counts valid prefetch entries. `demand_cnt` counts valid non-prefetch entries, except read entries of kind transaction begin or transaction commit.
- R10: `occ` always equals the number of valid entries. This holds when an insert and a completion fall in the same cycle, and each is then applied.
- R11: A completion that matches no entry sets `err_nomatch`, which stays set until reset. It produces no response and leaves `occ` unchanged.
- R12: After reset `occ`, `demand_cnt`, `pf_cnt`, `rsp_valid` and `err_nomatch` are 0, and `chk_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_addr | input | AW | Address probed by the admission check |
| chk_ok | output | 1 | 1 = request may be issued, 0 = stall |
| ins_valid | input | 1 | Insert request present |
| ins_ready | output | 1 | Insert can be taken this cycle |
| ins_thread | input | TW | Issuing thread |
| ins_kind | input | 4 | Request kind code |
| ins_addr | input | AW | Request address |
| ins_pf | input | 1 | Request is a prefetch |
| ins_ts | input | TSW | Issue timestamp |
| ins_dup | output | 1 | Accepted insert overwrote an existing entry |
| ins_fwd | output | 1 | Accepted insert is a new miss to forward |
| cmp_valid | input | 1 | Completion present |
| cmp_write | input | 1 | Completion targets the write table |
| cmp_addr | input | AW | Completed line address |
| cmp_thr_known | input | 1 | `cmp_thread` is meaningful |
| cmp_thread | input | TW | Thread of the completion when known |
| rsp_valid | output | 1 | An entry was freed last cycle |
| rsp_thread | output | TW | Owner of the freed entry |
| rsp_pf | output | 1 | Freed entry was a prefetch |
| rsp_deliver | output | 1 | Data return to the requester |
| err_nomatch | output | 1 | Sticky: a completion matched nothing |
| occ | output | CW | Number of outstanding entries |
| demand_cnt | output | CW | Outstanding demand entries |
| pf_cnt | output | CW | Outstanding prefetch entries |

## Verification
The assertions check the following on every cycle. The occupancy counter agrees with an independent count of valid slots. A new insert grows the count by one and a duplicate leaves it alone. A stall on the insert port happens only with the array full. Admission never opens at or above the limit. The error flag never drops, and every response follows a completion. Only the bench scenarios can show the rest. These are the table choice by kind, the line masking of offset bits, the choice between two threads holding the same line by timestamp or by an explicit thread, the suppression of data return for prefetches, the exclusion of transaction markers from the demand count, and the exact response contents, which a scoreboard queue compares entry by entry.

// File: rtl/omt_pkg.sv
package omt_pkg;

  localparam logic [3:0] KIND_LOAD    = 4'h0;
  localparam logic [3:0] KIND_IFETCH  = 4'h1;
  localparam logic [3:0] KIND_TLOAD   = 4'h2;
  localparam logic [3:0] KIND_TBEGIN  = 4'h3;
  localparam logic [3:0] KIND_TCOMMIT = 4'h4;
  localparam logic [3:0] KIND_STORE   = 4'h8;
  localparam logic [3:0] KIND_TSTORE  = 4'h9;
  localparam logic [3:0] KIND_TXLOAD  = 4'hA;
  localparam logic [3:0] KIND_ATOMIC  = 4'hB;

  // bit 3 of the kind code selects the write table
  function automatic logic kind_to_write(input logic [3:0] k);
    return k[3];
  endfunction

  // transaction boundary markers, never counted as demand
  function automatic logic kind_is_marker(input logic [3:0] k);
    return (k == KIND_TBEGIN) || (k == KIND_TCOMMIT);
  endfunction

endpackage

// File: rtl/omt_match.sv
module omt_match #(
  parameter int DEPTH = 8,
  parameter int LW    = 12,
  parameter int TW    = 1
) (
  input  logic [DEPTH-1:0]         vld,
  input  logic [DEPTH-1:0][LW-1:0] line,
  input  logic [DEPTH-1:0]         wr,
  input  logic [DEPTH-1:0][TW-1:0] thr,
  input  logic [LW-1:0]            key_line,
  input  logic                     key_wr,
  input  logic [TW-1:0]            key_thr,
  input  logic                     use_wr,
  input  logic                     use_thr,
  output logic [DEPTH-1:0]         hit
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = vld[i] && (line[i] == key_line)
                 && (!use_wr  || (wr[i]  == key_wr))
                 && (!use_thr || (thr[i] == key_thr));
  end

endmodule

// File: rtl/omt_pick.sv
module omt_pick #(
  parameter int DEPTH = 8,
  parameter int TSW   = 16,
  parameter int IW    = 3
) (
  input  logic [DEPTH-1:0]          cand,
  input  logic [DEPTH-1:0][TSW-1:0] ts,
  output logic                      found,
  output logic [IW-1:0]             idx
);

  logic [TSW-1:0] best;

  // strict less-than keeps the lowest slot on equal timestamps
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!found || (ts[i] < best))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = ts[i];
      end
    end
  end

endmodule

// File: rtl/omt_tally.sv
module omt_tally
  import omt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic [DEPTH-1:0]       vld,
  input  logic [DEPTH-1:0]       pf,
  input  logic [DEPTH-1:0][3:0]  kind,
  output logic [CW-1:0]          n_vld,
  output logic [CW-1:0]          n_dem,
  output logic [CW-1:0]          n_pf
);

  always_comb begin
    n_vld = '0;
    n_dem = '0;
    n_pf  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i]) begin
        n_vld = n_vld + CW'(1);
        if (pf[i])
          n_pf = n_pf + CW'(1);
        else if (kind_to_write(kind[i]) || !kind_is_marker(kind[i]))
          n_dem = n_dem + CW'(1);
      end
    end
  end

endmodule

// File: rtl/omt_tracker.sv
module omt_tracker
  import omt_pkg::*;
#(
  parameter int NTHR   = 2,
  parameter int DEPTH  = 8,
  parameter int AW     = 16,
  parameter int OFFW   = 4,
  parameter int TSW    = 16,
  parameter int MAXOUT = 6,
  localparam int TW    = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  chk_addr,
  output logic           chk_ok,
  input  logic           ins_valid,
  output logic           ins_ready,
  input  logic [TW-1:0]  ins_thread,
  input  logic [3:0]     ins_kind,
  input  logic [AW-1:0]  ins_addr,
  input  logic           ins_pf,
  input  logic [TSW-1:0] ins_ts,
  output logic           ins_dup,
  output logic           ins_fwd,
  input  logic           cmp_valid,
  input  logic           cmp_write,
  input  logic [AW-1:0]  cmp_addr,
  input  logic           cmp_thr_known,
  input  logic [TW-1:0]  cmp_thread,
  output logic           rsp_valid,
  output logic [TW-1:0]  rsp_thread,
  output logic           rsp_pf,
  output logic           rsp_deliver,
  output logic           err_nomatch,
  output logic [CW-1:0]  occ,
  output logic [CW-1:0]  demand_cnt,
  output logic [CW-1:0]  pf_cnt
);

  localparam int LW = AW - OFFW;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // slot storage
  logic [DEPTH-1:0]          e_vld;
  logic [DEPTH-1:0][LW-1:0]  e_line;
  logic [DEPTH-1:0][TW-1:0]  e_thr;
  logic [DEPTH-1:0][3:0]     e_kind;
  logic [DEPTH-1:0]          e_pf;
  logic [DEPTH-1:0][TSW-1:0] e_ts;
  logic [DEPTH-1:0]          e_wr;
  logic [CW-1:0]             occ_q;
  logic                      err_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_wr
    assign e_wr[i] = kind_to_write(e_kind[i]);
  end

  logic [LW-1:0] chk_line, ins_line, cmp_line;
  logic          ins_wr;
  assign chk_line = chk_addr[AW-1:OFFW];
  assign ins_line = ins_addr[AW-1:OFFW];
  assign cmp_line = cmp_addr[AW-1:OFFW];
  assign ins_wr   = kind_to_write(ins_kind);

  // admission: any thread, either table
  logic [DEPTH-1:0] chk_hit;
  omt_match #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) u_chk_match (
    .vld(e_vld), .line(e_line), .wr(e_wr), .thr(e_thr),
    .key_line(chk_line), .key_wr(1'b0), .key_thr('0),
    .use_wr(1'b0), .use_thr(1'b0), .hit(chk_hit)
  );
  assign chk_ok = (occ_q < CW'(MAXOUT)) && !(|chk_hit);

  // insert: same thread, same table
  logic [DEPTH-1:0] ins_hit;
  omt_match #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) u_ins_match (
    .vld(e_vld), .line(e_line), .wr(e_wr), .thr(e_thr),
    .key_line(ins_line), .key_wr(ins_wr), .key_thr(ins_thread),
    .use_wr(1'b1), .use_thr(1'b1), .hit(ins_hit)
  );

  // completion: chosen table, thread optional
  logic [DEPTH-1:0] cmp_hit;
  omt_match #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) u_cmp_match (
    .vld(e_vld), .line(e_line), .wr(e_wr), .thr(e_thr),
    .key_line(cmp_line), .key_wr(cmp_write), .key_thr(cmp_thread),
    .use_wr(1'b1), .use_thr(cmp_thr_known), .hit(cmp_hit)
  );

  logic          sel_found;
  logic [IW-1:0] sel_idx;
  omt_pick #(.DEPTH(DEPTH), .TSW(TSW), .IW(IW)) u_pick (
    .cand(cmp_hit), .ts(e_ts), .found(sel_found), .idx(sel_idx)
  );

  logic [CW-1:0] n_vld;
  omt_tally #(.DEPTH(DEPTH), .CW(CW)) u_tally (
    .vld(e_vld), .pf(e_pf), .kind(e_kind),
    .n_vld(n_vld), .n_dem(demand_cnt), .n_pf(pf_cnt)
  );

  // lowest free slot and the duplicate slot
  logic          free_found, dup_found;
  logic [IW-1:0] free_idx, dup_idx;
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    dup_found  = 1'b0;
    dup_idx    = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!e_vld[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
      if (ins_hit[i]) begin
        dup_found = 1'b1;
        dup_idx   = IW'(i);
      end
    end
  end

  logic ins_go, ins_new, cmp_go;
  logic [IW-1:0] wr_idx;
  assign ins_ready = dup_found || free_found;
  assign ins_go    = ins_valid && ins_ready;
  assign ins_new   = ins_go && !dup_found;
  assign ins_dup   = ins_go && dup_found;
  assign ins_fwd   = ins_new;
  assign cmp_go    = cmp_valid && sel_found;
  assign wr_idx    = dup_found ? dup_idx : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld      <= '0;
      e_line     <= '0;
      e_thr      <= '0;
      e_kind     <= '0;
      e_pf       <= '0;
      e_ts       <= '0;
      occ_q      <= '0;
      err_q      <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_thread <= '0;
      rsp_pf     <= 1'b0;
    end else begin
      rsp_valid <= cmp_go;
      if (cmp_go) begin
        rsp_thread <= e_thr[sel_idx];
        rsp_pf     <= e_pf[sel_idx];
      end
      if (cmp_valid && !sel_found)
        err_q <= 1'b1;
      if (ins_go) begin
        e_vld[wr_idx]  <= 1'b1;
        e_line[wr_idx] <= ins_line;
        e_thr[wr_idx]  <= ins_thread;
        e_kind[wr_idx] <= ins_kind;
        e_pf[wr_idx]   <= ins_pf;
        e_ts[wr_idx]   <= ins_ts;
      end
      // a completion of the slot being overwritten wins
      if (cmp_go)
        e_vld[sel_idx] <= 1'b0;
      occ_q <= occ_q + CW'(ins_new) - CW'(cmp_go);
    end
  end

  assign rsp_deliver = rsp_valid && !rsp_pf;
  assign err_nomatch = err_q;
  assign occ         = occ_q;

  // R10
  occ_tracks_entries_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q == n_vld);

  // R5
  new_entry_grows_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fwd && !cmp_go) |=> (occ_q == $past(occ_q) + CW'(1)));

  // R5
  dup_keeps_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_dup && !cmp_go) |=> (occ_q == $past(occ_q)));

  // R6
  ready_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_ready |-> (occ_q == CW'(DEPTH)));

  // R3
  admit_under_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok |-> (occ_q < CW'(MAXOUT)));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R7
  rsp_after_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmp_valid));

  // R7
  pick_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_found |-> cmp_hit[sel_idx]);

endmodule

// File: tb/sim_omt_tracker.sv
`timescale 1ns/1ps
module sim_omt_tracker;

  localparam int NTHR = 2, DEPTH = 8, AW = 16, OFFW = 4, TSW = 16, MAXOUT = 6;
  localparam int TW = 1;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0]  chk_addr = '0;
  logic           chk_ok;
  logic           ins_valid = 1'b0;
  logic           ins_ready;
  logic [TW-1:0]  ins_thread = '0;
  logic [3:0]     ins_kind = '0;
  logic [AW-1:0]  ins_addr = '0;
  logic           ins_pf = 1'b0;
  logic [TSW-1:0] ins_ts = '0;
  logic           ins_dup, ins_fwd;
  logic           cmp_valid = 1'b0;
  logic           cmp_write = 1'b0;
  logic [AW-1:0]  cmp_addr = '0;
  logic           cmp_thr_known = 1'b0;
  logic [TW-1:0]  cmp_thread = '0;
  logic           rsp_valid;
  logic [TW-1:0]  rsp_thread;
  logic           rsp_pf, rsp_deliver, err_nomatch;
  logic [CW-1:0]  occ, demand_cnt, pf_cnt;

  always #5 clk = ~clk;

  omt_tracker #(.NTHR(NTHR), .DEPTH(DEPTH), .AW(AW), .OFFW(OFFW), .TSW(TSW), .MAXOUT(MAXOUT)) u0 (
    .clk(clk), .rst_n(rst_n), .chk_addr(chk_addr), .chk_ok(chk_ok),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_thread(ins_thread),
    .ins_kind(ins_kind), .ins_addr(ins_addr), .ins_pf(ins_pf), .ins_ts(ins_ts),
    .ins_dup(ins_dup), .ins_fwd(ins_fwd),
    .cmp_valid(cmp_valid), .cmp_write(cmp_write), .cmp_addr(cmp_addr),
    .cmp_thr_known(cmp_thr_known), .cmp_thread(cmp_thread),
    .rsp_valid(rsp_valid), .rsp_thread(rsp_thread), .rsp_pf(rsp_pf),
    .rsp_deliver(rsp_deliver), .err_nomatch(err_nomatch),
    .occ(occ), .demand_cnt(demand_cnt), .pf_cnt(pf_cnt)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct { int thr; int pf; } exp_t;
  exp_t q[$];
  exp_t got;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R7 unexpected response: actual 1 expected 0");
      end else begin
        got = q.pop_front();
        chk("R7 response thread", int'(rsp_thread), got.thr);
        chk("R8 response prefetch flag", int'(rsp_pf), got.pf);
        chk("R8 data return", int'(rsp_deliver), (got.pf == 0) ? 1 : 0);
      end
    end
  end

  task automatic drive_ins(input int thr, input int kind, input int addr, input int pf, input int ts);
    ins_valid  = 1'b1;
    ins_thread = TW'(thr);
    ins_kind   = 4'(kind);
    ins_addr   = AW'(addr);
    ins_pf     = pf[0];
    ins_ts     = TSW'(ts);
  endtask

  task automatic drive_cmp(input int wr, input int addr, input int known, input int thr,
                           input int exp_found, input int exp_thr, input int exp_pf);
    exp_t e;
    cmp_valid     = 1'b1;
    cmp_write     = wr[0];
    cmp_addr      = AW'(addr);
    cmp_thr_known = known[0];
    cmp_thread    = TW'(thr);
    if (exp_found != 0) begin
      e.thr = exp_thr;
      e.pf  = exp_pf;
      q.push_back(e);
    end
  endtask

  task automatic ins(input int thr, input int kind, input int addr, input int pf, input int ts,
                     input int e_ready, input int e_dup, input int e_fwd, input string tag);
    drive_ins(thr, kind, addr, pf, ts);
    #1;
    chk({tag, " ins_ready"}, int'(ins_ready), e_ready);
    chk({tag, " ins_dup"}, int'(ins_dup), e_dup);
    chk({tag, " ins_fwd"}, int'(ins_fwd), e_fwd);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic cmp(input int wr, input int addr, input int known, input int thr,
                     input int exp_found, input int exp_thr, input int exp_pf);
    drive_cmp(wr, addr, known, thr, exp_found, exp_thr, exp_pf);
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic probe(input int addr, input int exp, input string tag);
    chk_addr = AW'(addr);
    #1;
    chk(tag, int'(chk_ok), exp);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 occ", int'(occ), 0);
    chk("R12 demand", int'(demand_cnt), 0);
    chk("R12 prefetch", int'(pf_cnt), 0);
    chk("R12 rsp_valid", int'(rsp_valid), 0);
    chk("R12 err", int'(err_nomatch), 0);
    probe(16'h1230, 1, "R12 chk_ok");

    // R5 new read entry
    ins(0, 4'h0, 16'h1234, 0, 10, 1, 0, 1, "R5 new load");
    chk("R10 occ after new", int'(occ), 1);
    chk("R9 demand one load", int'(demand_cnt), 1);

    // R4 / R2 admission on same line, other offset
    probe(16'h123C, 0, "R4 same line blocked");
    probe(16'h1240, 1, "R2 next line open");

    // R5 / R2 duplicate through a different offset
    ins(0, 4'h0, 16'h1238, 0, 11, 1, 1, 0, "R5 duplicate");
    chk("R5 occ after dup", int'(occ), 1);

    // R1 store goes to the write table: not a duplicate
    ins(0, 4'h8, 16'h1230, 0, 12, 1, 0, 1, "R1 store separate table");
    chk("R1 occ", int'(occ), 2);

    // R9 marker and prefetch counting
    ins(1, 4'h3, 16'h2000, 0, 13, 1, 0, 1, "R9 tx begin");
    ins(1, 4'h0, 16'h3000, 1, 14, 1, 0, 1, "R9 prefetch load");
    chk("R9 demand", int'(demand_cnt), 2);
    chk("R9 prefetch", int'(pf_cnt), 1);
    ins(0, 4'h4, 16'h4000, 0, 15, 1, 0, 1, "R9 tx commit");
    ins(1, 4'h9, 16'h5000, 0, 16, 1, 0, 1, "R1 tx store");
    chk("R10 occ six", int'(occ), 6);
    chk("R9 demand with markers", int'(demand_cnt), 3);
    probe(16'h7000, 0, "R3 limit reached");

    // R8 prefetch completion, thread not given
    cmp(0, 16'h3000, 0, 0, 1, 1, 1);
    chk("R8 occ after prefetch done", int'(occ), 5);
    chk("R9 prefetch after done", int'(pf_cnt), 0);
    probe(16'h7000, 1, "R3 below limit again");

    // R7 two threads on one line
    ins(1, 4'h0, 16'h1230, 0, 5, 1, 0, 1, "R7 second thread same line");
    cmp(0, 16'h1234, 1, 0, 1, 0, 0);
    cmp(0, 16'h1230, 0, 0, 1, 1, 0);
    chk("R7 occ", int'(occ), 4);
    ins(0, 4'h2, 16'h6000, 0, 20, 1, 0, 1, "R7 older thread0");
    ins(1, 4'h1, 16'h6008, 0, 30, 1, 0, 1, "R7 younger thread1");
    cmp(0, 16'h6000, 0, 0, 1, 0, 0);
    cmp(0, 16'h6000, 0, 0, 1, 1, 0);

    // R1 write-table completion
    cmp(1, 16'h1230, 0, 0, 1, 0, 0);
    chk("R1 occ after write done", int'(occ), 3);

    // R11 completion in the wrong table matches nothing
    chk("R11 err before", int'(err_nomatch), 0);
    cmp(0, 16'h5000, 0, 0, 0, 0, 0);
    chk("R11 err set", int'(err_nomatch), 1);
    chk("R11 occ unchanged", int'(occ), 3);
    @(negedge clk);
    chk("R11 err sticky", int'(err_nomatch), 1);

    // R10 insert and completion in the same cycle
    drive_ins(0, 4'h0, 16'h8000, 0, 40);
    drive_cmp(1, 16'h5000, 0, 0, 1, 1, 0);
    #1;
    chk("R10 same-cycle fwd", int'(ins_fwd), 1);
    @(negedge clk);
    ins_valid = 1'b0;
    cmp_valid = 1'b0;
    chk("R10 occ same cycle", int'(occ), 3);
    chk("R9 demand markers excluded", int'(demand_cnt), 1);

    // R6 fill all slots
    for (int k = 0; k < 5; k++)
      ins(0, 4'h0, 16'h9000 + k * 16'h1000, 0, 50 + k, 1, 0, 1, "R6 fill");
    chk("R6 occ full", int'(occ), 8);
    ins(0, 4'h0, 16'hE000, 0, 60, 0, 0, 0, "R6 full stall");
    chk("R6 occ unchanged on stall", int'(occ), 8);
    probe(16'hE000, 0, "R3 full");
    ins(0, 4'h0, 16'h9004, 0, 61, 1, 1, 0, "R6 dup accepted when full");
    chk("R6 occ after dup", int'(occ), 8);
    chk("R9 demand full", int'(demand_cnt), 6);

    repeat (2) @(negedge clk);
    chk("R7 scoreboard drained", q.size(), 0);
    report();
  end

endmodule